// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Unit

This block lets two processors signal each other through a small memory-mapped peripheral. Each processor owns a 4-bit interrupt word. Any bus master can raise bits in a word by writing ones to that processor's set register, and can lower bits by writing ones to its clear register. A status register returns the current word. Each processor has a level interrupt line that stays high while its word is nonzero. Software on the target processor uses that line as a doorbell. It reads status to learn which of the four reasons were posted, then acknowledges them through the clear register.

The block sits behind a single 32-bit APB-style slave port that decodes a 4 KB window. It always completes an access in one access phase and never signals an error. Twelve fixed read-only identification words sit at the top of the window, so discovery software can recognise the block.

Top module: `dbell_unit`

## Requirements
- R1: The status register of CPU0 (offset 0x00) and of CPU1 (offset 0x10) returns that CPU's interrupt word in bits [3:0], and bits [31:4] of the read data are zero.
- R2: A write to a set register (CPU0 at 0x04, CPU1 at 0x14) ORs write-data bits [3:0] into that CPU's word. Data bits [31:4] are ignored.
- R3: A write to a clear register (CPU0 at 0x08, CPU1 at 0x18) clears each word bit whose write-data bit in [3:0] is 1 and leaves the other bits unchanged.
- R4: Interrupt output irq_o[n] equals "word n is nonzero" as it was one clock earlier. It therefore changes on the clock edge after the write edge.
- R5: Reads of the set and clear registers, and of any offset with no register, return 0.
- R6: Writes to the status registers, to the ID registers, or to offsets with no register leave both words unchanged.
- R7: The twelve word-spaced ID registers from 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: An active-low reset clears both words and drives both interrupt outputs low.
- R9: pready_o is always 1 and pslverr_o is always 0.
- R10: Decoding uses address bits [11:2] only. Bits [1:0] do not change which register is accessed.
- R11: A write takes effect only on the clock edge where psel_i, penable_i and pwrite_i are all high. A setup phase without penable_i changes nothing.
- R12: The two CPU words are independent: a write aimed at one CPU never changes the other CPU's word or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access-phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address inside the 4 KB window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid while a read is selected |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Never an error |
| irq_o | output | 2 | Level interrupt per CPU (bit n for CPU n) |

## Verification
The hardest situation to reach from the ports is a clear write that has to preserve a sparse pattern of bits in a word that is already partly set, while the other CPU's word holds different bits. That situation can hide wrong masking or crossed CPU selects. A long stream of seeded random set and clear writes with random data reaches it, mixed with random unmapped and read-only addresses and random low address bits. After every write, a bench model checks both status words and both interrupt lines. Directed cases cover the one-cycle interrupt lag, a setup phase with no access phase, a reset while words are nonzero, and the full ID table.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned WORD_W     = 4;
    localparam int unsigned NUM_CPU    = 2;
    localparam int unsigned ID_COUNT   = 12;
    localparam int unsigned ID_W       = 8;
    localparam int unsigned WADDR_W    = ADDR_W - 2;
    localparam int unsigned ID_IDX_W   = $clog2(ID_COUNT);
    localparam logic [WADDR_W-1:0] ID_FIRST_WORD = WADDR_W'(10'h3F4);
    // word offsets inside one CPU's 16-byte slot
    localparam int unsigned SLOT_STATUS = 0;
    localparam int unsigned SLOT_SET    = 1;
    localparam int unsigned SLOT_CLEAR  = 2;
    localparam int unsigned SLOT_WORDS  = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2
    } word_op_e;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int unsigned N_CPU = NUM_CPU
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [N_CPU-1:0]    stat_hit_o,
    output logic [N_CPU-1:0]    set_hit_o,
    output logic [N_CPU-1:0]    clr_hit_o,
    output logic                id_hit_o,
    output logic [ID_IDX_W-1:0] id_idx_o
);
    logic [WADDR_W-1:0] waddr;
    assign waddr = addr_i[ADDR_W-1:2];

    for (genvar c = 0; c < N_CPU; c++) begin : g_slot
        localparam logic [WADDR_W-1:0] BASE = WADDR_W'(c * SLOT_WORDS);
        assign stat_hit_o[c] = (waddr == BASE + WADDR_W'(SLOT_STATUS));
        assign set_hit_o[c]  = (waddr == BASE + WADDR_W'(SLOT_SET));
        assign clr_hit_o[c]  = (waddr == BASE + WADDR_W'(SLOT_CLEAR));
    end

    logic [WADDR_W-1:0] id_off;
    assign id_off   = waddr - ID_FIRST_WORD;
    assign id_hit_o = (waddr >= ID_FIRST_WORD) &&
                      (id_off < WADDR_W'(ID_COUNT));
    assign id_idx_o = id_off[ID_IDX_W-1:0];
endmodule

// File: rtl/dbell_id_rom.sv
module dbell_id_rom
    import dbell_pkg::*;
(
    input  logic [ID_IDX_W-1:0] idx_i,
    output logic [ID_W-1:0]     value_o
);
    always_comb begin
        unique case (idx_i)
            4'd0:    value_o = 8'h04;
            4'd1:    value_o = 8'h00;
            4'd2:    value_o = 8'h00;
            4'd3:    value_o = 8'h00;
            4'd4:    value_o = 8'h56;
            4'd5:    value_o = 8'hB8;
            4'd6:    value_o = 8'h0B;
            4'd7:    value_o = 8'h00;
            4'd8:    value_o = 8'h0D;
            4'd9:    value_o = 8'hF0;
            4'd10:   value_o = 8'h05;
            4'd11:   value_o = 8'hB1;
            default: value_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/dbell_word_bank.sv
module dbell_word_bank
    import dbell_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  word_op_e     op_i,
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] word_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         irq;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.irq = |state_q.word;
        unique case (op_i)
            OP_SET:   state_d.word = state_q.word | bits_i;
            OP_CLEAR: state_d.word = state_q.word & ~bits_i;
            default:  state_d.word = state_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o = state_q.word;
    assign irq_o  = state_q.irq;

    AST_SET_BITS_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SET) |=> ((word_o & $past(bits_i)) == $past(bits_i))); // R2
    AST_CLEAR_BITS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CLEAR) |=> ((word_o & $past(bits_i)) == '0)); // R3
    AST_CLEAR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CLEAR) |=> ((word_o & ~$past(bits_i)) == ($past(word_o) & ~$past(bits_i)))); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD) |=> $stable(word_o)); // R6
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
    import dbell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [BUS_W-1:0]  pwdata_i,
    output logic [BUS_W-1:0]  prdata_o,
    output logic              pready_o,
    output logic              pslverr_o,
    output logic [NUM_CPU-1:0] irq_o
);
    logic [NUM_CPU-1:0]  stat_hit, set_hit, clr_hit;
    logic                id_hit;
    logic [ID_IDX_W-1:0] id_idx;
    logic [ID_W-1:0]     id_value;
    logic                wr_access;
    logic                rd_select;
    logic [WORD_W-1:0]   word [NUM_CPU];

    assign wr_access = psel_i & penable_i & pwrite_i;
    assign rd_select = psel_i & ~pwrite_i;

    dbell_decode #(.N_CPU(NUM_CPU)) u_decode (
        .addr_i     (paddr_i),
        .stat_hit_o (stat_hit),
        .set_hit_o  (set_hit),
        .clr_hit_o  (clr_hit),
        .id_hit_o   (id_hit),
        .id_idx_o   (id_idx)
    );

    dbell_id_rom u_id_rom (
        .idx_i   (id_idx),
        .value_o (id_value)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        word_op_e op;
        always_comb begin
            op = OP_HOLD;
            if (wr_access && set_hit[c]) begin
                op = OP_SET;
            end else if (wr_access && clr_hit[c]) begin
                op = OP_CLEAR;
            end
        end

        dbell_word_bank #(.W(WORD_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .op_i   (op),
            .bits_i (pwdata_i[WORD_W-1:0]),
            .word_o (word[c]),
            .irq_o  (irq_o[c])
        );

        AST_IRQ_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o[c] == ($past(word[c]) != '0))); // R4
        AST_OTHER_CPU_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_access && !set_hit[c] && !clr_hit[c]) |=> $stable(word[c])); // R12
    end

    always_comb begin
        prdata_o = '0;
        if (rd_select) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (stat_hit[c]) begin
                    prdata_o = BUS_W'(word[c]);
                end
            end
            if (id_hit) begin
                prdata_o = BUS_W'(id_value);
            end
        end
    end

    assign pready_o  = 1'b1;
    assign pslverr_o = 1'b0;

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_select && (stat_hit != '0)) |-> (prdata_o[BUS_W-1:WORD_W] == '0)); // R1
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_select && ((set_hit | clr_hit) != '0)) |-> (prdata_o == '0)); // R5
    AST_SETUP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (psel_i && !penable_i) |=> ($stable(word[0]) && $stable(word[1]))); // R11
    AST_HITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat_hit, set_hit, clr_hit, id_hit})); // R10
endmodule

// File: tb/dbell_unit_test.sv
module dbell_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [1:0]  irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [3:0] m [2];

    always #5 clk = ~clk;

    dbell_unit uut (
        .clk(clk), .rst_n(rst_n), .psel_i(psel), .penable_i(penable),
        .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
        .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
    );

    function automatic logic [7:0] id_table(input int i);
        case (i)
            0: return 8'h04;  4: return 8'h56;  5: return 8'hB8;
            6: return 8'h0B;  8: return 8'h0D;  9: return 8'hF0;
            10: return 8'h05; 11: return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int w = int'(a[11:2]);
        if (w == 0) return {28'h0, m[0]};
        if (w == 4) return {28'h0, m[1]};
        if (w >= 'h3F4) return {24'h0, id_table(w - 'h3F4)};
        return 32'h0;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        case (int'(a[11:2]))
            1: m[0] = m[0] | d[3:0];
            2: m[0] = m[0] & ~d[3:0];
            5: m[1] = m[1] | d[3:0];
            6: m[1] = m[1] & ~d[3:0];
            default: ;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_land(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        model_write(a, d);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_land(a, d);
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        rd(12'h000, v); check({tag, " status0"}, v, {28'h0, m[0]});
        rd(12'h010, v); check({tag, " status1"}, v, {28'h0, m[1]});
        check({tag, " irq"}, {30'h0, irq}, {30'h0, (m[1] != 0), (m[0] != 0)});
    endtask

    initial begin
        logic [31:0] v;
        m[0] = '0; m[1] = '0;
        void'($urandom(32'h0D0BE11));
        repeat (3) @(negedge clk);
        check("R8 irq in reset", {30'h0, irq}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        check("R9 pready", {31'h0, pready}, 32'h1);
        check("R9 pslverr", {31'h0, pslverr}, 32'h0);
        check_state("R8 after reset");

        // R4: interrupt lags the landing edge by one clock
        wr_land(12'h004, 32'hFFFF_FFF5);
        check("R4 irq not yet", {31'h0, irq[0]}, 32'h0);
        @(negedge clk);
        check("R4 irq raised", {31'h0, irq[0]}, 32'h1);
        check_state("R2 R12 set cpu0 upper ignored");
        rd(12'h000, v); check("R1 status upper zero", v, 32'h5);

        wr(12'h00B, 32'h4);   // R10 low bits ignored on clear
        check_state("R3 R10 clear one bit");
        wr(12'h015, 32'hA);   // R10 set cpu1
        check_state("R2 R12 set cpu1");

        rd(12'h004, v); check("R5 read set0", v, 32'h0);
        rd(12'h018, v); check("R5 read clr1", v, 32'h0);
        rd(12'h40C, v); check("R5 read unmapped", v, 32'h0);

        wr(12'h000, 32'hF); check_state("R6 write status0");
        wr(12'h010, 32'h0); check_state("R6 write status1");
        wr(12'hFD0, 32'hF); check_state("R6 write id");
        wr(12'h00C, 32'hF); check_state("R6 write unmapped");

        for (int i = 0; i < 12; i++) begin
            rd(12'hFD0 + 12'(4 * i), v);
            check($sformatf("R7 id %0d", i), v, {24'h0, id_table(i)});
        end

        // R11: setup phase only, no access phase
        @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 12'h004; pwdata = 32'hF;
        @(negedge clk); psel = 0; pwrite = 0;
        @(negedge clk);
        check_state("R11 setup only");

        wr(12'h008, 32'hF);
        check_state("R3 clear all cpu0");

        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [31:0] d = $urandom;
            int k = int'($urandom % 10);
            case (k)
                0, 1: a = 12'h004;
                2, 3: a = 12'h008;
                4: a = 12'h014;
                5: a = 12'h018;
                6: a = ($urandom % 2) ? 12'h000 : 12'h010;
                7: a = 12'hFD0 + 12'(4 * ($urandom % 12));
                default: a = 12'($urandom % 4096) & 12'hFFC;
            endcase
            a[1:0] = 2'($urandom);
            wr(a, d);
            check_state($sformatf("R2 R3 R6 R12 random @%03h", a));
        end

        // R8: reset with live words
        wr(12'h004, 32'h3); wr(12'h014, 32'hC);
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        check("R8 irq cleared", {30'h0, irq}, 32'h0);
        rst_n = 1; m[0] = '0; m[1] = '0;
        check_state("R8 words cleared");

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule